// File: doc/BRIEF.md
# Low-Power State Register Access Gate

This block sits between a host register port and the rest of a device's register file. It holds the current power state: one normal state and two power-saving states. It also holds a ready flag. From these two it decides, for every host request, whether to forward the request to the device registers or to reject it. The block owns the power-control register. A host read of that register returns the ready flag and the current state, and a host write to it can send the device into either saving state.

While ready is clear, only the power-control register can be read. Every write is dropped, with one exception: a write of any data to the byte-test register while in a saving state. That write wakes the device. The state returns to normal at once, and ready comes back after a fixed settling count of clock cycles. The block also drives three clock-enable outputs, one each for the data path, the MAC and the PHY. Entering a saving state leaves all configuration registers untouched.

Top module: `pwr_gate_top`

## Requirements
- R1: After synchronous reset the state is normal (pstate 2'b00), ready is 1, clk_en is 3'b111, and acc_err and rsp_vld are 0.
- R2: With ready set, a read or write of any address other than the power-control address is forwarded in the same cycle. dev_rd_en or dev_wr_en goes high, with dev_addr and dev_wdata equal to the request. The read data from dev_rdata appears on rsp_data with rsp_vld one cycle later, and acc_err stays 0.
- R3: A read of the power-control address is always allowed and never forwarded. One cycle later rsp_data holds ready in bit 0 and pstate in bits 2:1, with all other bits 0.
- R4: With ready set, a write to the power-control address takes its state field from wdata bits 2:1. Value 01 enters the first saving state (pstate 01) and value 10 enters the second (pstate 10); in both cases ready reads 0 from the next cycle on. Values 00 and 11 change nothing.
- R5: With ready clear, a read of any address other than the power-control address is not forwarded. One cycle later rsp_data is 0 and acc_err is high for that one cycle.
- R6: With ready clear, writes are never forwarded and do not change pstate, including writes to the power-control address. acc_err stays 0.
- R7: In a saving state, a write to the byte-test address is not forwarded. It sets pstate to 00 from the next cycle on, and ready rises exactly SETTLE_CYCLES clock cycles after the cycle of that write.
- R8: During the settling interval, accesses are still gated as in R5 and R6, and a further byte-test write neither restarts nor shortens the interval.
- R9: clk_en bit 0 enables the data path, bit 1 the MAC and bit 2 the PHY. In pstate 00 all three are 1, in pstate 01 only bit 0 is 0, and in pstate 10 all three are 0.
- R10: dev_rd_en and dev_wr_en are never high while ready is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Host request valid for this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| dev_rdata | input | DATA_W | Read data from the device registers for dev_addr |
| dev_rd_en | output | 1 | Forwarded read strobe |
| dev_wr_en | output | 1 | Forwarded write strobe |
| dev_addr | output | ADDR_W | Forwarded address |
| dev_wdata | output | DATA_W | Forwarded write data |
| rsp_vld | output | 1 | Read response valid, one cycle after a read |
| rsp_data | output | DATA_W | Read response data |
| acc_err | output | 1 | One-cycle strobe for a rejected read |
| ready | output | 1 | Ready flag |
| pstate | output | 2 | Power state: 00 normal, 01 light saving, 10 deep saving |
| clk_en | output | 3 | Clock enables: bit 0 data, bit 1 MAC, bit 2 PHY |

## Verification
The gate is exercised by sweeping every address with both a read and a write in each of four conditions: normal and ready, light saving, deep saving, and the settling interval after a wake. Comparing the sweeps shows that the filter depends on the ready flag alone and not on which saving state is active. The sweeps also show that the power-control and byte-test addresses are the only ones treated differently. All four state-field values are written, and field writes are also tried while not ready, which separates the encodings that are accepted from the ones that are ignored. The settling count is measured both for a plain wake and for one with extra accesses inside the interval, which shows that those accesses neither restart nor shorten it.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

    typedef enum logic [1:0] {
        PS_NORM  = 2'b00,
        PS_LIGHT = 2'b01,
        PS_DEEP  = 2'b10
    } pstate_e;

    localparam int CE_W    = 3;
    localparam int CE_DATA = 0;
    localparam int CE_MAC  = 1;
    localparam int CE_PHY  = 2;

    // Decoded outcome of one host request
    typedef struct packed {
        logic fwd_rd;
        logic fwd_wr;
        logic own_rd;
        logic own_wr;
        logic wake;
        logic rej_rd;
    } acc_dec_t;

    // Whether clock-enable bit idx stays on in state s
    function automatic logic ce_on(pstate_e s, int idx);
        case (s)
            PS_NORM:  return 1'b1;
            PS_LIGHT: return (idx != CE_DATA);
            default:  return 1'b0;
        endcase
    endfunction

    // Legal state-field values; 00 and 11 give no change
    function automatic logic field_is_sleep(logic [1:0] f);
        return (f == PS_LIGHT) || (f == PS_DEEP);
    endfunction

endpackage

// File: rtl/pwr_access_filter.sv
module pwr_access_filter
    import pwr_gate_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] PMC_ADDR = 4'd13,
    parameter logic [ADDR_W-1:0] BT_ADDR  = 4'd6
) (
    input  logic              req_vld,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              ready,
    input  pstate_e           cur_state,
    output acc_dec_t          dec
);
    logic hit_pmc;
    logic hit_bt;
    logic rd;
    logic wr;

    always_comb begin
        hit_pmc = (req_addr == PMC_ADDR);
        hit_bt  = (req_addr == BT_ADDR);
        rd      = req_vld && !req_wr;
        wr      = req_vld && req_wr;

        dec.own_rd = rd && hit_pmc;
        dec.fwd_rd = rd && !hit_pmc && ready;
        dec.rej_rd = rd && !hit_pmc && !ready;
        dec.own_wr = wr && hit_pmc && ready;
        dec.fwd_wr = wr && !hit_pmc && ready;
        dec.wake   = wr && hit_bt && !ready && (cur_state != PS_NORM);
    end
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
    import pwr_gate_pkg::*;
#(
    parameter int SETTLE_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       own_wr,
    input  logic [1:0] field,
    input  logic       wake,
    output pstate_e    cur_state,
    output logic       ready
);
    localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic             settling;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= PS_NORM;
            ready     <= 1'b1;
            settling  <= 1'b0;
            cnt       <= '0;
        end else if (own_wr && field_is_sleep(field)) begin
            cur_state <= pstate_e'(field);
            ready     <= 1'b0;
        end else if (wake) begin
            cur_state <= PS_NORM;
            settling  <= 1'b1;
            cnt       <= '0;
        end else if (settling) begin
            if (cnt == CNT_LAST) begin
                ready    <= 1'b1;
                settling <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwr_clk_enables.sv
module pwr_clk_enables
    import pwr_gate_pkg::*;
(
    input  pstate_e         cur_state,
    output logic [CE_W-1:0] clk_en
);
    for (genvar i = 0; i < CE_W; i++) begin : g_ce
        assign clk_en[i] = ce_on(cur_state, i);
    end
endmodule

// File: rtl/pwr_gate_top.sv
module pwr_gate_top
    import pwr_gate_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int SETTLE_CYCLES = 8,
    parameter logic [ADDR_W-1:0] PMC_ADDR = 4'd13,
    parameter logic [ADDR_W-1:0] BT_ADDR  = 4'd6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_rd_en,
    output logic              dev_wr_en,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              rsp_vld,
    output logic [DATA_W-1:0] rsp_data,
    output logic              acc_err,
    output logic              ready,
    output logic [1:0]        pstate,
    output logic [CE_W-1:0]   clk_en
);
    acc_dec_t dec;
    pstate_e  cur_state;
    logic [DATA_W-1:0] own_val;

    pwr_access_filter #(
        .ADDR_W(ADDR_W), .PMC_ADDR(PMC_ADDR), .BT_ADDR(BT_ADDR)
    ) u_filter (
        .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr),
        .ready(ready), .cur_state(cur_state), .dec(dec)
    );

    pwr_state_ctl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_state (
        .clk(clk), .rst(rst), .own_wr(dec.own_wr), .field(req_wdata[2:1]),
        .wake(dec.wake), .cur_state(cur_state), .ready(ready)
    );

    pwr_clk_enables u_ce (.cur_state(cur_state), .clk_en(clk_en));

    assign pstate    = cur_state;
    assign dev_rd_en = dec.fwd_rd;
    assign dev_wr_en = dec.fwd_wr;
    assign dev_addr  = req_addr;
    assign dev_wdata = req_wdata;

    always_comb begin
        own_val      = '0;
        own_val[0]   = ready;
        own_val[2:1] = cur_state;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld  <= 1'b0;
            rsp_data <= '0;
            acc_err  <= 1'b0;
        end else begin
            rsp_vld <= dec.own_rd || dec.fwd_rd || dec.rej_rd;
            acc_err <= dec.rej_rd;
            if (dec.own_rd)      rsp_data <= own_val;
            else if (dec.fwd_rd) rsp_data <= dev_rdata;
            else                 rsp_data <= '0;
        end
    end
endmodule

// File: rtl/pwr_gate_chk.sv
module pwr_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic       ready,
    input logic [1:0] pstate,
    input logic [2:0] clk_en,
    input logic       acc_err,
    input logic       dev_rd_en,
    input logic       dev_wr_en
);
    a_r10_rd_gated: assert property (@(posedge clk) disable iff (rst)
        dev_rd_en |-> ready);

    a_r6_wr_gated: assert property (@(posedge clk) disable iff (rst)
        dev_wr_en |-> ready);

    a_r5_err_only_unready: assert property (@(posedge clk) disable iff (rst)
        $rose(acc_err) |-> $past(!ready));

    a_r4_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (pstate != 2'b00 && $past(pstate) == 2'b00) |-> !ready);

    a_r7_ready_in_norm: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (pstate == 2'b00));

    a_r9_deep_off: assert property (@(posedge clk) disable iff (rst)
        (pstate == 2'b10) |-> (clk_en == 3'b000));

    a_r9_light_data_off: assert property (@(posedge clk) disable iff (rst)
        (pstate == 2'b01) |-> (clk_en == 3'b110));
endmodule

bind pwr_gate_top pwr_gate_chk u_chk (
    .clk(clk), .rst(rst), .ready(ready), .pstate(pstate), .clk_en(clk_en),
    .acc_err(acc_err), .dev_rd_en(dev_rd_en), .dev_wr_en(dev_wr_en)
);

// File: tb/pwr_gate_top_tb.sv
module pwr_gate_top_tb;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int SETTLE = 8;
    localparam logic [ADDR_W-1:0] PMC = 4'd13;
    localparam logic [ADDR_W-1:0] BT  = 4'd6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_vld = 1'b0, req_wr = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] dev_rdata;
    logic dev_rd_en, dev_wr_en, rsp_vld, acc_err, ready;
    logic [ADDR_W-1:0] dev_addr;
    logic [DATA_W-1:0] dev_wdata, rsp_data;
    logic [1:0] pstate;
    logic [2:0] clk_en;

    int n_run = 0;
    int n_fail = 0;
    logic m_ready = 1'b1;
    logic [1:0] m_ps = 2'b00;

    always #2 clk = ~clk;

    assign dev_rdata = 16'hC000 | 16'(dev_addr);

    pwr_gate_top #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYCLES(SETTLE),
        .PMC_ADDR(PMC), .BT_ADDR(BT)
    ) u_dut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .dev_rdata(dev_rdata),
        .dev_rd_en(dev_rd_en), .dev_wr_en(dev_wr_en), .dev_addr(dev_addr),
        .dev_wdata(dev_wdata), .rsp_vld(rsp_vld), .rsp_data(rsp_data),
        .acc_err(acc_err), .ready(ready), .pstate(pstate), .clk_en(clk_en)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_ce(input logic [1:0] s);
        return (s == 2'b00) ? 3'b111 : (s == 2'b01) ? 3'b110 : 3'b000;
    endfunction

    task automatic check_status(input string tag);
        chk(32'(pstate), 32'(m_ps), {tag, " R4/R7 pstate"});
        chk(32'(ready), 32'(m_ready), {tag, " R4/R7 ready"});
        chk(32'(clk_en), 32'(exp_ce(m_ps)), {tag, " R9 clk_en"});
    endtask

    // One access; called at a negedge, returns at a negedge
    task automatic access(input logic wr, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input string tag);
        logic own, fwd, err;
        logic [DATA_W-1:0] exp_rd;
        own = (a == PMC);
        fwd = m_ready && !own;
        err = !wr && !m_ready && !own;
        exp_rd = own ? DATA_W'({m_ps, m_ready}) : (m_ready ? (16'hC000 | 16'(a)) : '0);
        req_vld = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        #1;
        chk(32'(dev_rd_en), 32'(!wr && fwd), {tag, " R2/R5/R10 dev_rd_en"});
        chk(32'(dev_wr_en), 32'(wr && fwd), {tag, " R2/R6/R10 dev_wr_en"});
        if (fwd) begin
            chk(32'(dev_addr), 32'(a), {tag, " R2 dev_addr"});
            if (wr) chk(32'(dev_wdata), 32'(d), {tag, " R2 dev_wdata"});
        end
        @(posedge clk);
        @(negedge clk);
        req_vld = 1'b0;
        if (wr) begin
            if (m_ready && own && (d[2:1] == 2'b01 || d[2:1] == 2'b10)) begin
                m_ps = d[2:1]; m_ready = 1'b0;
            end else if (!m_ready && a == BT && m_ps != 2'b00) begin
                m_ps = 2'b00;
            end
        end
        chk(32'(rsp_vld), 32'(!wr), {tag, " R2/R3/R5 rsp_vld"});
        chk(32'(acc_err), 32'(err), {tag, " R5 acc_err"});
        if (!wr) chk(32'(rsp_data), 32'(exp_rd), {tag, " R2/R3/R5 rsp_data"});
        check_status(tag);
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < (1 << ADDR_W); a++)
            access(1'b0, ADDR_W'(a), '0, {tag, " read"});
        for (int a = 0; a < (1 << ADDR_W); a++)
            if (ADDR_W'(a) != BT && (m_ready || ADDR_W'(a) != PMC))
                access(1'b1, ADDR_W'(a), 16'h5A5A, {tag, " write"});
    endtask

    task automatic wait_ready(input int already, input string tag);
        int n;
        n = already;
        while (!ready && n < 4 * SETTLE) begin
            @(posedge clk); @(negedge clk); n++;
        end
        chk(32'(n), 32'(SETTLE), {tag, " R7/R8 settle count"});
        m_ready = 1'b1;
        check_status({tag, " after settle"});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(32'(rsp_vld), 0, "R1 rsp_vld");
        chk(32'(acc_err), 0, "R1 acc_err");
        check_status("R1 reset");

        sweep("R2 normal");
        // R4 ignored field values
        access(1'b1, PMC, 16'h0006, "R4 field 11");
        access(1'b1, PMC, 16'h0000, "R4 field 00");

        // Light saving
        access(1'b1, PMC, 16'h0002, "R4 enter light");
        sweep("R5 R6 light");
        access(1'b1, PMC, 16'h0004, "R6 field write unready");
        access(1'b1, PMC, 16'h0000, "R6 field 00 unready");
        access(1'b1, BT, 16'h1234, "R7 wake light");
        wait_ready(0, "R7 light");

        // Deep saving
        access(1'b1, PMC, 16'h0004, "R4 enter deep");
        sweep("R5 R6 deep");
        access(1'b1, BT, 16'h0000, "R7 wake deep");
        // R8: accesses inside the settling interval
        access(1'b0, 4'd3, '0, "R8 read in settle");
        access(1'b1, BT, 16'hFFFF, "R8 second wake");
        access(1'b1, 4'd2, 16'h0F0F, "R8 write in settle");
        wait_ready(3, "R8 deep");
        sweep("R2 normal again");

        // R1 reset out of deep state
        access(1'b1, PMC, 16'h0004, "R1 prep deep");
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        m_ps = 2'b00; m_ready = 1'b1;
        check_status("R1 reset from deep");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule